// File: doc/BRIEF.md
# Iterative CORDIC Vector Magnitude Unit

This block returns the length of a two-component vector, sqrt(a² + b²), for a pair of signed two's-complement fixed-point operands that share one binary-point position. A typical use is envelope recovery after coherent demodulation, where the operands are the in-phase and quadrature samples and the result is the envelope value. The result is an unsigned integer one bit wider than an operand, with the same binary point as the inputs.

The engine applies CORDIC in vectoring mode. The sign of the first operand is folded away, so the vector lies in the right half-plane. Then one shift-and-add micro-rotation per clock turns the vector toward the positive x axis, with angles that shrink at each step. After the last step, a single cycle of constant-coefficient shift-add scaling removes the accumulated CORDIC gain. No multiplier, square-root circuit or lookup table is used. For 32-bit operands a result takes 33 clocks, which is far below a budget of thousands of cycles per sample.

A one-cycle `start` strobe captures the operands when the unit is idle. `busy` stays high while the calculation runs. `done` pulses for one cycle when `mag` carries the new result.

Top module: `cordic_mag`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `mag` is 0.
- R2: For any operand pair in any quadrant, `mag` differs from sqrt(a² + b²) rounded to the nearest integer by at most 3.
- R3: Full-scale operands do not wrap. (-2^(IN_W-1), -2^(IN_W-1)) gives about 2^(IN_W-1)·√2. For IN_W = 32 that is 3037000500 ± 3. The internal x value never goes negative while the unit is busy.
- R4: The operand pair (0, 0) gives exactly 0.
- R5: `done` rises ITER + 1 clock edges after the edge that samples an accepted `start`.
- R6: `done` is high for exactly one clock per accepted `start`.
- R7: A `start` that arrives while `busy` is 1 is ignored. The running result, its operands and its latency stay unchanged.
- R8: `mag` changes only in the cycle where `done` is 1, and it holds its value until the next `done`.
- R9: `busy` rises in the cycle after an accepted `start`, stays 1 until `done` appears, and is 0 in the `done` cycle. A new `start` is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe that captures the operands when idle |
| a_in | input | IN_W | First operand, signed |
| b_in | input | IN_W | Second operand, signed |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: `mag` carries a new result |
| mag | output | IN_W+1 | Unsigned vector magnitude |

## Verification
A wrong rotation direction, a wrong shift or a truncated guard bit corrupts the x register. This never shows at the ports until `done` pulses ITER + 1 edges later, and then it shows as a magnitude error well beyond a few LSBs. An exhaustive sweep of a 6-bit configuration therefore exposes any such fault in every quadrant. A sequencer fault shows at once as a wrong latency, a `done` longer than one cycle, or a result that follows operands offered while busy. Full-scale operands on the 32-bit configuration show any missing headroom as a wrapped, much smaller result.

// File: rtl/cordic_mag_pkg.sv
package cordic_mag_pkg;

    // Phases of the iterative engine
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ROTATE = 2'd1,
        PH_SCALE  = 2'd2
    } phase_e;

    // Reciprocal of the CORDIC gain as an unsigned fraction with GAIN_FB bits
    localparam int GAIN_FB = 32;
    localparam logic [GAIN_FB-1:0] INV_GAIN = 32'h9B74_EDA8;

    // Fractional guard bits that absorb truncation of the shifted terms
    function automatic int guard_bits(input int iters);
        return $clog2(iters) + 2;
    endfunction

    // Width of the iteration index
    function automatic int idx_bits(input int iters);
        return (iters > 1) ? $clog2(iters) : 1;
    endfunction

endpackage

// File: rtl/cordic_mag_precond.sv
module cordic_mag_precond
    import cordic_mag_pkg::*;
#(
    parameter int IN_W = 32,
    parameter int XW   = 41,
    parameter int FRAC = 7
) (
    input  logic signed [IN_W-1:0] a_in,
    input  logic signed [IN_W-1:0] b_in,
    output logic signed [XW-1:0]   x0,
    output logic signed [XW-1:0]   y0
);

    localparam int EXT = XW - IN_W;

    logic signed [XW-1:0] a_ext;
    logic signed [XW-1:0] b_ext;
    logic signed [XW-1:0] a_abs;

    assign a_ext = {{EXT{a_in[IN_W-1]}}, a_in};
    assign b_ext = {{EXT{b_in[IN_W-1]}}, b_in};

    // Folding the sign of the first component keeps the length and lands
    // the vector in the right half-plane, inside the convergence range.
    assign a_abs = a_in[IN_W-1] ? -a_ext : a_ext;

    assign x0 = a_abs <<< FRAC;
    assign y0 = b_ext <<< FRAC;

endmodule

// File: rtl/cordic_mag_microrot.sv
module cordic_mag_microrot #(
    parameter int XW = 41,
    parameter int SW = 5
) (
    input  logic signed [XW-1:0] x_in,
    input  logic signed [XW-1:0] y_in,
    input  logic        [SW-1:0] shift,
    output logic signed [XW-1:0] x_out,
    output logic signed [XW-1:0] y_out
);

    logic signed [XW-1:0] x_sh;
    logic signed [XW-1:0] y_sh;

    always_comb begin
        x_sh = x_in >>> shift;
        y_sh = y_in >>> shift;
        if (y_in[XW-1]) begin
            // below the axis: turn counter-clockwise
            x_out = x_in - y_sh;
            y_out = y_in + x_sh;
        end else begin
            // on or above the axis: turn clockwise
            x_out = x_in + y_sh;
            y_out = y_in - x_sh;
        end
    end

endmodule

// File: rtl/cordic_mag_descale.sv
module cordic_mag_descale
    import cordic_mag_pkg::*;
#(
    parameter int XW    = 41,
    parameter int FRAC  = 7,
    parameter int OUT_W = 33
) (
    input  logic signed [XW-1:0]    x_in,
    output logic        [OUT_W-1:0] mag_out
);

    localparam int PW = XW + GAIN_FB;
    localparam int SH = GAIN_FB + FRAC;

    logic [PW-1:0] x_wide;
    logic [PW-1:0] term [GAIN_FB];
    logic [PW-1:0] acc;

    assign x_wide = PW'($unsigned(x_in));

    // One shifted copy of x per set bit of the inverse gain
    for (genvar k = 0; k < GAIN_FB; k++) begin : g_tap
        if (INV_GAIN[k]) begin : g_on
            assign term[k] = x_wide << k;
        end else begin : g_off
            assign term[k] = '0;
        end
    end

    // Sum of the taps, with a half-LSB of the output added for rounding
    always_comb begin
        acc = PW'(1) << (SH - 1);
        for (int k = 0; k < GAIN_FB; k++) begin
            acc = acc + term[k];
        end
    end

    assign mag_out = OUT_W'(acc >> SH);

endmodule

// File: rtl/cordic_mag_seq.sv
module cordic_mag_seq
    import cordic_mag_pkg::*;
#(
    parameter int ITER = 32,
    parameter int SW   = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          load,
    output logic          rot_en,
    output logic          scale_en,
    output logic          done,
    output logic [SW-1:0] step
);

    localparam logic [SW-1:0] LAST_STEP = SW'(ITER - 1);

    phase_e        ph_q;
    logic [SW-1:0] step_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            step_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        ph_q   <= PH_ROTATE;
                        step_q <= '0;
                    end
                end
                PH_ROTATE: begin
                    if (step_q == LAST_STEP) begin
                        ph_q <= PH_SCALE;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                PH_SCALE: begin
                    ph_q   <= PH_IDLE;
                    done_q <= 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (ph_q != PH_IDLE);
    assign load     = start && (ph_q == PH_IDLE);
    assign rot_en   = (ph_q == PH_ROTATE);
    assign scale_en = (ph_q == PH_SCALE);
    assign done     = done_q;
    assign step     = step_q;

endmodule

// File: rtl/cordic_mag.sv
module cordic_mag
    import cordic_mag_pkg::*;
#(
    parameter int IN_W = 32,
    parameter int ITER = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic signed [IN_W-1:0] a_in,
    input  logic signed [IN_W-1:0] b_in,
    output logic               busy,
    output logic               done,
    output logic [IN_W:0]      mag
);

    localparam int FRAC  = guard_bits(ITER);
    localparam int XW    = IN_W + 2 + FRAC;
    localparam int OUT_W = IN_W + 1;
    localparam int SW    = idx_bits(ITER);

    logic                 load;
    logic                 rot_en;
    logic                 scale_en;
    logic [SW-1:0]        step;
    logic signed [XW-1:0] x0;
    logic signed [XW-1:0] y0;
    logic signed [XW-1:0] x_q;
    logic signed [XW-1:0] y_q;
    logic signed [XW-1:0] x_nx;
    logic signed [XW-1:0] y_nx;
    logic [OUT_W-1:0]     mag_nx;
    logic [OUT_W-1:0]     mag_q;

    cordic_mag_seq #(
        .ITER (ITER),
        .SW   (SW)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .busy     (busy),
        .load     (load),
        .rot_en   (rot_en),
        .scale_en (scale_en),
        .done     (done),
        .step     (step)
    );

    cordic_mag_precond #(
        .IN_W (IN_W),
        .XW   (XW),
        .FRAC (FRAC)
    ) u_precond (
        .a_in (a_in),
        .b_in (b_in),
        .x0   (x0),
        .y0   (y0)
    );

    cordic_mag_microrot #(
        .XW (XW),
        .SW (SW)
    ) u_rot (
        .x_in  (x_q),
        .y_in  (y_q),
        .shift (step),
        .x_out (x_nx),
        .y_out (y_nx)
    );

    cordic_mag_descale #(
        .XW    (XW),
        .FRAC  (FRAC),
        .OUT_W (OUT_W)
    ) u_descale (
        .x_in    (x_q),
        .mag_out (mag_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q   <= '0;
            y_q   <= '0;
            mag_q <= '0;
        end else begin
            if (load) begin
                x_q <= x0;
                y_q <= y0;
            end else if (rot_en) begin
                x_q <= x_nx;
                y_q <= y_nx;
            end
            if (scale_en) begin
                mag_q <= mag_nx;
            end
        end
    end

    assign mag = mag_q;

endmodule

// File: rtl/cordic_mag_chk.sv
module cordic_mag_chk #(
    parameter int IN_W = 32,
    parameter int ITER = 32,
    parameter int XW   = 41
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic [IN_W:0]        mag,
    input logic signed [XW-1:0] x_q,
    input logic                 rot_en
);

    // Cycles since the accepted start, counted outside the design
    logic [15:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else if (start && !busy) begin
            lat_q <= 16'd1;
        end else if (busy) begin
            lat_q <= lat_q + 16'd1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && (mag == '0))); // R1

    AST_X_GROWS: assert property (@(posedge clk) disable iff (rst)
        rot_en |=> ($signed(x_q) >= $signed($past(x_q)))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        busy |-> !x_q[XW-1]); // R3

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_q == 16'(ITER + 2))); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(mag)); // R8

    AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R9

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9

endmodule

bind cordic_mag cordic_mag_chk #(
    .IN_W (IN_W),
    .ITER (ITER),
    .XW   (XW)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .mag    (mag),
    .x_q    (x_q),
    .rot_en (rot_en)
);

// File: tb/cordic_mag_bench.sv
module cordic_mag_bench;

    localparam int BIG_W  = 32;
    localparam int BIG_N  = 32;
    localparam int SML_W  = 6;
    localparam int SML_N  = 8;
    localparam int TOL    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic                    bg_start = 1'b0;
    logic signed [BIG_W-1:0] bg_a = '0;
    logic signed [BIG_W-1:0] bg_b = '0;
    logic                    bg_busy;
    logic                    bg_done;
    logic [BIG_W:0]          bg_mag;

    logic                    sm_start = 1'b0;
    logic signed [SML_W-1:0] sm_a = '0;
    logic signed [SML_W-1:0] sm_b = '0;
    logic                    sm_busy;
    logic                    sm_done;
    logic [SML_W:0]          sm_mag;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    cordic_mag #(.IN_W(BIG_W), .ITER(BIG_N)) u_cordic_mag (
        .clk(clk), .rst(rst), .start(bg_start), .a_in(bg_a), .b_in(bg_b),
        .busy(bg_busy), .done(bg_done), .mag(bg_mag)
    );

    cordic_mag #(.IN_W(SML_W), .ITER(SML_N)) u_cordic_mag_small (
        .clk(clk), .rst(rst), .start(sm_start), .a_in(sm_a), .b_in(sm_b),
        .busy(sm_busy), .done(sm_done), .mag(sm_mag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint ideal(input longint a, input longint b);
        real ra, rb;
        ra = real'(a);
        rb = real'(b);
        return longint'($floor($sqrt(ra * ra + rb * rb) + 0.5));
    endfunction

    function automatic longint absdiff(input longint p, input longint q);
        return (p > q) ? p - q : q - p;
    endfunction

    // One calculation on the 32-bit instance; optionally offers a second
    // start with other operands while busy.
    task automatic big_op(input longint a, input longint b, input bit poke,
                          output longint m, output int lat);
        longint held;
        @(negedge clk);
        bg_a = a[31:0];
        bg_b = b[31:0];
        bg_start = 1'b1;
        @(negedge clk);
        bg_start = 1'b0;
        lat = 0;
        check(bg_busy == 1'b1, "R9 busy after start", longint'(bg_busy), 1);
        while (1) begin
            @(negedge clk);
            lat++;
            if (bg_done || lat > 100) break;
            if (poke && lat == 5) begin
                bg_a = 32'sd7;
                bg_b = 32'sd9;
                bg_start = 1'b1;
            end else begin
                bg_start = 1'b0;
            end
        end
        bg_start = 1'b0;
        m = longint'(bg_mag);
        check(lat == BIG_N + 1, "R5 latency", lat, BIG_N + 1);
        check(bg_busy == 1'b0, "R9 idle at done", longint'(bg_busy), 0);
        held = m;
        @(negedge clk);
        check(bg_done == 1'b0, "R6 single done", longint'(bg_done), 0);
        repeat (3) @(negedge clk);
        check(longint'(bg_mag) == held, "R8 result held", longint'(bg_mag), held);
    endtask

    task automatic sm_op(input int a, input int b, output longint m, output int lat);
        @(negedge clk);
        sm_a = SML_W'(a);
        sm_b = SML_W'(b);
        sm_start = 1'b1;
        @(negedge clk);
        sm_start = 1'b0;
        lat = 0;
        while (1) begin
            @(negedge clk);
            lat++;
            if (sm_done || lat > 50) break;
        end
        m = longint'(sm_mag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : stimulus
        longint m;
        longint e;
        int     lat;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: quiet after reset
        check(bg_busy == 1'b0, "R1 busy", longint'(bg_busy), 0);
        check(bg_done == 1'b0, "R1 done", longint'(bg_done), 0);
        check(bg_mag == '0, "R1 mag", longint'(bg_mag), 0);
        check(sm_mag == '0 && !sm_busy && !sm_done, "R1 small", longint'(sm_mag), 0);

        // R4: zero vector
        big_op(0, 0, 1'b0, m, lat);
        check(m == 0, "R4 zero vector", m, 0);

        // R3: full-scale corners
        big_op(-64'sd2147483648, -64'sd2147483648, 1'b0, m, lat);
        e = ideal(-64'sd2147483648, -64'sd2147483648);
        check(absdiff(m, e) <= TOL, "R3 both most negative", m, e);
        big_op(-64'sd2147483648, 0, 1'b0, m, lat);
        check(absdiff(m, 64'sd2147483648) <= TOL, "R3 negative axis", m, 64'sd2147483648);
        big_op(0, -64'sd2147483648, 1'b0, m, lat);
        check(absdiff(m, 64'sd2147483648) <= TOL, "R3 negative b axis", m, 64'sd2147483648);
        big_op(64'sd2147483647, 64'sd2147483647, 1'b0, m, lat);
        e = ideal(64'sd2147483647, 64'sd2147483647);
        check(absdiff(m, e) <= TOL, "R3 both most positive", m, e);

        // R2: all four quadrants on the wide instance
        big_op(30000, -40000, 1'b0, m, lat);
        check(absdiff(m, 50000) <= TOL, "R2 quadrant IV", m, 50000);
        big_op(-123456789, 987654321, 1'b0, m, lat);
        e = ideal(-123456789, 987654321);
        check(absdiff(m, e) <= TOL, "R2 quadrant II", m, e);
        big_op(-1000000007, -3, 1'b0, m, lat);
        e = ideal(-1000000007, -3);
        check(absdiff(m, e) <= TOL, "R2 quadrant III", m, e);
        big_op(1, 1, 1'b0, m, lat);
        check(absdiff(m, 1) <= TOL, "R2 tiny vector", m, 1);

        // R7: start offered while busy is ignored
        big_op(600000, 800000, 1'b1, m, lat);
        check(absdiff(m, 1000000) <= TOL, "R7 ignored start", m, 1000000);
        repeat (4) @(negedge clk);
        check(bg_busy == 1'b0 && bg_done == 1'b0, "R7 no second run",
              longint'(bg_busy), 0);

        // R2 and R5: exhaustive sweep of the narrow instance
        for (int i = -(1 << (SML_W - 1)); i < (1 << (SML_W - 1)); i++) begin
            for (int j = -(1 << (SML_W - 1)); j < (1 << (SML_W - 1)); j++) begin
                sm_op(i, j, m, lat);
                e = ideal(longint'(i), longint'(j));
                check(absdiff(m, e) <= TOL, "R2 sweep magnitude", m, e);
                check(lat == SML_N + 1, "R5 sweep latency", lat, SML_N + 1);
                if (i == 0 && j == 0) begin
                    check(m == 0, "R4 sweep zero", m, 0);
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule